// File: doc/BRIEF.md
# Reset Pulse Duration Counter

This block measures how long an active-low reset button is held down. It counts cycles of the 25 MHz reference clock, so each count step is 40 ns. Software reads the result through a small register port and uses it to tell a short press from a long press, for example to trigger a return to factory settings. The button line is asynchronous to the clock, so it passes through a synchroniser before the counter uses it.

The count saturates at its all-ones value and does not wrap. With the default 29-bit width, that limit is about 21.4 s. When the button is released, the count freezes and keeps its value until software clears it. Software clears it by writing a one to bit 31 of the count register. An optional comparator raises an output while the count is at or above a threshold that software programs. Software computes that threshold as the number of seconds multiplied by 25,000,000.

The register port is a plain control path with no back-pressure. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr`, so no handshake is involved.

Top module: `rpd_top`

## Requirements
- R1: `btn_n` passes through a two-flop synchroniser. If `btn_n` is low at rising edge k, the first increment happens at edge k+2.
- R2: While the synchronised button is low and the count is below its limit, the count rises by exactly one per clock. Each step is one 40 ns reference period.
- R3: The count stops at 2^CNT_W-1 and stays there while the button stays low. It never wraps to zero.
- R4: While the synchronised button is high, the count holds its value.
- R5: A write to address 0 with bit 31 of `wdata` set makes the count zero at that edge. The clear wins over an increment in the same cycle.
- R6: A write to address 0 with bit 31 clear leaves the count unchanged.
- R7: A press that follows a clear counts up from zero. A press without a clear in between continues from the held value.
- R8: A read of address 0 returns the count in bits CNT_W-1:0 (28:0 by default). All higher bits, including 30:29, read as zero.
- R9: Address 1 holds a CNT_W-bit threshold that can be written and read back. Its reset value is all ones. Other addresses read as zero and ignore writes.
- R10: `cmp_hit` is high exactly when the count is greater than or equal to the threshold.
- R11: After reset, the count is zero, the threshold is all ones and `cmp_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| btn_n | input | 1 | Asynchronous active-low reset-button level |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (0 count, 1 threshold) |
| wdata | input | DATA_W | Write data; bit 31 at address 0 clears the count |
| rdata | output | DATA_W | Combinational read data for `addr` |
| cmp_hit | output | 1 | High while count is at or above the threshold |

## Verification
The bound checker watches the counter on every cycle. It checks single-step increments, holding at the limit, freezing while released, the clear, the zero upper read bits and that `cmp_hit` stays high until a clear or a threshold write. Only the bench scenarios can show the two-cycle synchroniser latency and the difference between resuming after a release and restarting after a clear. The same applies to the ignored write without bit 31 and the decoding of unused addresses. For these, the bench compares `rdata` and `cmp_hit` against its own model on every clock.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  // Register addresses decoded by the port; values are part of the register map.
  localparam int unsigned ADDR_COUNT  = 0;
  localparam int unsigned ADDR_THRESH = 1;

  // Decoded write strobes handed from the register port to the datapath.
  typedef struct packed {
    logic clr;     // clear the measured count
    logic thr_we;  // load the threshold register
  } rpd_wr_s;
endpackage

// File: rtl/rpd_sync.sv
module rpd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rpd_counter.sv
module rpd_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,   // synchronised button held down
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clr)                        cnt_q <= '0;
    else if (active && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt = cnt_q;
  assign sat = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rpd_regif.sv
module rpd_regif
  import rpd_pkg::*;
#(
  parameter int unsigned CNT_W   = 29,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CLR_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output rpd_wr_s           wr,
  output logic [CNT_W-1:0]  thr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_COUNT);
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(ADDR_THRESH);

  logic [CNT_W-1:0] thr_q;

  always_comb begin
    wr.clr    = wr_en && (addr == A_CNT) && wdata[CLR_BIT];
    wr.thr_we = wr_en && (addr == A_THR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thr_q <= '1;
    else if (wr.thr_we) thr_q <= wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CNT)      rdata[CNT_W-1:0] = cnt;
    else if (addr == A_THR) rdata[CNT_W-1:0] = thr_q;
  end

  assign thr = thr_q;
endmodule

// File: rtl/rpd_cmp.sv
module rpd_cmp #(
  parameter int unsigned CNT_W  = 29,
  parameter bit          ENABLE = 1'b1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  output logic             hit
);
  generate
    if (ENABLE) begin : g_cmp
      assign hit = (cnt >= thr);
    end else begin : g_nocmp
      logic unused_inputs;
      assign unused_inputs = ^{cnt, thr};
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rpd_top.sv
module rpd_top
  import rpd_pkg::*;
#(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CLR_BIT     = 31,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_CMP     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cmp_hit
);
  logic             btn_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_q;
  logic             cnt_sat;
  rpd_wr_s          wr_s;
  logic             clr_pulse;

  rpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(btn_n), .q_sync(btn_sync_n)
  );

  rpd_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_BIT(CLR_BIT)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt_q), .wr(wr_s), .thr(thr_q), .rdata(rdata)
  );

  assign clr_pulse = wr_s.clr;

  rpd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(!btn_sync_n), .clr(clr_pulse),
    .cnt(cnt_q), .sat(cnt_sat)
  );

  rpd_cmp #(.CNT_W(CNT_W), .ENABLE(HAS_CMP)) u_cmp (
    .cnt(cnt_q), .thr(thr_q), .hit(cmp_hit)
  );
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              btn_sync_n,
  input logic              clr,
  input logic              thr_we,
  input logic              sat,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              cmp_hit
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2: one step per cycle while held and below the limit
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !btn_sync_n && !sat) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R3: saturation holds, no wrap
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == CMAX) |=> (cnt == CMAX));

  // R4: released button freezes the count
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && btn_sync_n) |=> $stable(cnt));

  // R5: clear strobe zeroes the count
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R8: bits above the count field read as zero at address 0
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[DATA_W-1:CNT_W] == '0));

  // R10: count never falls except by clear, so a hit persists until clear or threshold write
  p_hit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !clr && !thr_we) |=> cmp_hit);
endmodule

bind rpd_top rpd_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rpd_chk (
  .clk(clk), .rst_n(rst_n), .btn_sync_n(btn_sync_n), .clr(clr_pulse),
  .thr_we(wr_s.thr_we), .sat(cnt_sat), .cnt(cnt_q), .addr(addr),
  .rdata(rdata), .cmp_hit(cmp_hit)
);

// File: tb/test_rpd_top.sv
module test_rpd_top;
  localparam int CW = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        btn_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cmp_hit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt, m_thr;
  bit m_s1, m_s2;

  always #5 clk = ~clk;

  rpd_top #(.CNT_W(CW)) i_rpd_top (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_hit(cmp_hit)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_thr = MAXV; m_s1 = 1'b1; m_s2 = 1'b1;
    end else begin
      if (wr_en && addr == 2'd0 && wdata[31]) m_cnt = 0;
      else if (!m_s2 && m_cnt < MAXV) m_cnt = m_cnt + 1;
      if (wr_en && addr == 2'd1) m_thr = int'(wdata[CW-1:0]);
      m_s2 = m_s1;
      m_s1 = btn_n;
    end
  end

  function automatic logic [31:0] exp_rd();
    if (addr == 2'd0) return 32'(m_cnt);
    if (addr == 2'd1) return 32'(m_thr);
    return 32'd0;
  endfunction

  task automatic check(input string req);
    logic [31:0] e;
    logic eh;
    e = exp_rd();
    eh = (m_cnt >= m_thr);
    n_chk++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s cycle %0d rdata actual=%h expected=%h", req, cyc, rdata, e);
    end
    n_chk++;
    if (cmp_hit !== eh) begin
      n_bad++;
      $display("FAIL %s cycle %0d cmp_hit actual=%b expected=%b", req, cyc, cmp_hit, eh);
    end
  endtask

  task automatic steps(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req);
    end
  endtask

  task automatic wr1(input logic [1:0] a, input logic [31:0] d, input string req);
    @(negedge clk); check(req);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); check(req);
    wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    steps(2, "R11");
    // R1 latency and R2 stepping
    btn_n = 1'b0;
    steps(3, "R1");
    steps(17, "R2");
    // R4 freeze on release
    btn_n = 1'b1;
    steps(10, "R4");
    // R7 resume without clear
    btn_n = 1'b0;
    steps(6, "R7");
    btn_n = 1'b1;
    steps(4, "R7");
    // R6 write without bit 31
    wr1(2'd0, 32'h7FFF_FFFF, "R6");
    steps(3, "R6");
    // R5 clear while released
    wr1(2'd0, 32'h8000_0000, "R5");
    steps(3, "R5");
    // R7 restart from zero after clear
    btn_n = 1'b0;
    steps(8, "R7");
    // R5 clear while still pressed, clear wins
    wr1(2'd0, 32'h8000_0000, "R5");
    steps(4, "R5");
    // R3 saturation
    steps(80, "R3");
    // R8 full-width read of saturated count
    addr = 2'd0;
    @(negedge clk);
    n_chk++;
    if (rdata !== 32'(MAXV)) begin
      n_bad++;
      $display("FAIL R8 rdata actual=%h expected=%h", rdata, 32'(MAXV));
    end
    btn_n = 1'b1;
    steps(4, "R8");
    // R9 threshold register and unused addresses
    wr1(2'd1, 32'hFFFF_FF0A, "R9");
    addr = 2'd1; steps(2, "R9");
    wr1(2'd2, 32'h0000_0003, "R9");
    addr = 2'd2; steps(2, "R9");
    addr = 2'd3; steps(2, "R9");
    addr = 2'd1; steps(1, "R9");
    // R10 compare around threshold 10
    addr = 2'd0;
    wr1(2'd0, 32'h8000_0000, "R10");
    btn_n = 1'b0;
    steps(16, "R10");
    btn_n = 1'b1;
    steps(3, "R10");
    wr1(2'd1, 32'h0000_0030, "R10");
    steps(3, "R10");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule